// File: doc/BRIEF.md
# Bidirectional LCD Row Scan Driver

This block is the logic core of a row (common) driver for a dot-matrix LCD panel. A scan token moves through a chain of storage stages, one stage per row output. Each move happens when a slow shift clock falls. The shift clock is sampled by the system clock, so all state changes happen on rising edges of the system clock. A direction pin sets which end of the chain takes serial data and which end gives it out. A mode pin either keeps all stages as one chain or splits them into two half-length chains. The second half then takes its scan data from a separate serial input.

For every output, the block turns the stage bit, the frame-polarity input and an active-low blanking input into a 2-bit drive-level code. It registers that code on the system clock. An analog stage outside this block turns each code into one of four bias voltages. This produces an AC waveform across each row, so no row ever holds a steady DC level. The bit at the far end of the chain is presented at the output end of the chain, so several drivers can be placed in a cascade.

Top module: `lcdrow_scan`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0 and every level code to 00.
- R2: The chain moves only on a system-clock edge where the shift clock is sampled low after being sampled high. A rising shift clock, or a shift clock held steady, leaves every stage unchanged.
- R3: With `dir_rev` low and `split_mode` low, `ser_a_in` enters output 0 and each bit moves one output upward per shift. After NUM_STAGES shifts, the first bit sent sits at the highest output and the last bit sent sits at output 0.
- R4: With `dir_rev` high and `split_mode` low, `ser_b_in` enters the highest output and each bit moves one output downward per shift, which reverses the order across the outputs.
- R5: With `split_mode` high and `dir_rev` low, `ser_a_in` enters output 0 and fills outputs 0 to NUM_STAGES/2-1. `ser_c_in` enters output NUM_STAGES/2 and fills the upper half. No bit crosses from the lower half into the upper half.
- R6: With `split_mode` high and `dir_rev` high, `ser_b_in` enters output NUM_STAGES/2-1 and moves down through the lower half. `ser_c_in` enters the highest output and moves down through the upper half.
- R7: Output i drives its code on `level[2i+1:2i]`, one system clock after the stage bit and inputs it depends on. When `drive_en` is high, the code is chosen as follows:
  - bit 1 with `polarity` 1 gives 00 (lowest level);
  - bit 1 with `polarity` 0 gives 11 (top level);
  - bit 0 with `polarity` 1 gives 10 (upper middle level);
  - bit 0 with `polarity` 0 gives 01 (lower middle level).
- R8: When `drive_en` is low, every code becomes 00 one clock later, whatever the data or polarity.
- R9: `ser_b_out` always carries the highest output's stage bit and `ser_a_out` carries output 0's stage bit. `ser_b_oe` equals the inverse of `dir_rev` and `ser_a_oe` equals `dir_rev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Shift clock; chain moves on its falling edge |
| dir_rev | input | 1 | Direction select; high reverses the shift |
| split_mode | input | 1 | High: two half-length chains |
| ser_a_in | input | 1 | Serial data at the output-0 end |
| ser_b_in | input | 1 | Serial data at the high end |
| ser_c_in | input | 1 | Scan input of the upper half in split mode |
| polarity | input | 1 | Frame polarity |
| drive_en | input | 1 | Active-low blanking; low forces code 00 |
| ser_a_out | output | 1 | Cascade data at the output-0 end |
| ser_a_oe | output | 1 | Drive enable for the output-0 end pin |
| ser_b_out | output | 1 | Cascade data at the high end |
| ser_b_oe | output | 1 | Drive enable for the high-end pin |
| level | output | 2*NUM_STAGES | Drive-level code per output |

## Verification
The bench builds the block with NUM_STAGES set to 16, so each half is 8 stages long. With this size, a token can travel the whole chain in either direction in a few hundred cycles. Both split-mode seams are reached the same way. A token can also be shown to stay inside its half instead of crossing the middle. All four combinations of direction and mode can be driven one after another inside a single run, along with a long pseudo-random stretch. Blanking, both polarities and all four codes can also be compared on every output in that run.

// File: rtl/lcdrow_pkg.sv
package lcdrow_pkg;

  typedef enum logic [1:0] {
    LVL_REST     = 2'b00,
    LVL_LOW_MID  = 2'b01,
    LVL_HIGH_MID = 2'b10,
    LVL_TOP      = 2'b11
  } level_e;

  // Selected row swings between the outer levels; unselected rows between
  // the middle ones; polarity flips each frame; blanking parks at rest.
  function automatic level_e drive_code(input logic sel, input logic pol,
                                        input logic en);
    level_e c;
    if (!en)       c = LVL_REST;
    else if (sel)  c = pol ? LVL_REST : LVL_TOP;
    else           c = pol ? LVL_HIGH_MID : LVL_LOW_MID;
    return c;
  endfunction

endpackage

// File: rtl/lcdrow_edge.sv
module lcdrow_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  output logic fall
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b0;
    else        scl_q <= scl;
  end

  assign fall = rst_n & scl_q & ~scl;

  p_fall_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(scl) && !scl));

endmodule

// File: rtl/lcdrow_chain.sv
module lcdrow_chain #(
  parameter int NUM_STAGES = 160
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic                  dir_rev,
  input  logic                  split,
  input  logic                  in_a,
  input  logic                  in_b,
  input  logic                  in_c,
  output logic [NUM_STAGES-1:0] stage
);
  localparam int HALF = NUM_STAGES / 2;
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] stage_q;
  logic [NUM_STAGES-1:0] nxt;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic fwd_src;
    logic rev_src;
    if (i == 0) begin : g_f0
      assign fwd_src = in_a;
    end else if (i == HALF) begin : g_fh
      assign fwd_src = split ? in_c : stage_q[i-1];
    end else begin : g_fn
      assign fwd_src = stage_q[i-1];
    end
    if (i == LAST) begin : g_rl
      assign rev_src = split ? in_c : in_b;
    end else if (i == HALF - 1) begin : g_rh
      assign rev_src = split ? in_b : stage_q[i+1];
    end else begin : g_rn
      assign rev_src = stage_q[i+1];
    end
    assign nxt[i] = dir_rev ? rev_src : fwd_src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     stage_q <= '0;
    else if (shift) stage_q <= nxt;
  end

  assign stage = stage_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(stage_q));
  p_fwd_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !dir_rev && !split) |=>
      (stage_q[0] == $past(in_a)) && (stage_q[HALF] == $past(stage_q[HALF-1])));
  p_rev_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && dir_rev && !split) |=>
      (stage_q[LAST] == $past(in_b)) && (stage_q[0] == $past(stage_q[1])));
  p_split_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !dir_rev && split) |=>
      (stage_q[HALF] == $past(in_c)) && (stage_q[0] == $past(in_a)));
  p_split_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && dir_rev && split) |=>
      (stage_q[HALF-1] == $past(in_b)) && (stage_q[LAST] == $past(in_c)));

endmodule

// File: rtl/lcdrow_levels.sv
module lcdrow_levels
  import lcdrow_pkg::*;
#(
  parameter int NUM_STAGES = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_STAGES-1:0]   stage,
  input  logic                    polarity,
  input  logic                    drive_en,
  output logic [2*NUM_STAGES-1:0] level
);
  localparam int CODE_W = 2;

  logic [CODE_W*NUM_STAGES-1:0] level_q;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) level_q[CODE_W*i +: CODE_W] <= LVL_REST;
      else        level_q[CODE_W*i +: CODE_W] <= drive_code(stage[i], polarity, drive_en);
    end
  end

  assign level = level_q;

  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> (level_q == '0));
  p_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !polarity && stage[0]) |=> (level_q[1:0] == 2'b11));
  p_highmid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && polarity && !stage[0]) |=> (level_q[1:0] == 2'b10));

endmodule

// File: rtl/lcdrow_scan.sv
module lcdrow_scan #(
  parameter int NUM_STAGES = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl,
  input  logic                    dir_rev,
  input  logic                    split_mode,
  input  logic                    ser_a_in,
  input  logic                    ser_b_in,
  input  logic                    ser_c_in,
  input  logic                    polarity,
  input  logic                    drive_en,
  output logic                    ser_a_out,
  output logic                    ser_a_oe,
  output logic                    ser_b_out,
  output logic                    ser_b_oe,
  output logic [2*NUM_STAGES-1:0] level
);
  localparam int LAST = NUM_STAGES - 1;

  logic                  shift_evt;
  logic [NUM_STAGES-1:0] stage;

  lcdrow_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .scl   (scl),
    .fall  (shift_evt)
  );

  lcdrow_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (shift_evt),
    .dir_rev (dir_rev),
    .split   (split_mode),
    .in_a    (ser_a_in),
    .in_b    (ser_b_in),
    .in_c    (ser_c_in),
    .stage   (stage)
  );

  lcdrow_levels #(.NUM_STAGES(NUM_STAGES)) u_levels (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage    (stage),
    .polarity (polarity),
    .drive_en (drive_en),
    .level    (level)
  );

  assign ser_b_out = stage[LAST];
  assign ser_a_out = stage[0];
  assign ser_b_oe  = ~dir_rev;
  assign ser_a_oe  = dir_rev;

  p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ser_a_oe, ser_b_oe}));
  p_cascade_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !dir_rev && !split_mode) |=> (ser_b_out == $past(stage[LAST-1])));

endmodule

// File: tb/lcdrow_scan_test.sv
`timescale 1ns/1ps
module lcdrow_scan_test;
  localparam int N = 16;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b0, dir_rev = 1'b0, split_mode = 1'b0;
  logic ser_a_in = 1'b0, ser_b_in = 1'b0, ser_c_in = 1'b0;
  logic polarity = 1'b0, drive_en = 1'b0;
  logic ser_a_out, ser_a_oe, ser_b_out, ser_b_oe;
  logic [2*N-1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcdrow_scan #(.NUM_STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .dir_rev(dir_rev),
    .split_mode(split_mode), .ser_a_in(ser_a_in), .ser_b_in(ser_b_in),
    .ser_c_in(ser_c_in), .polarity(polarity), .drive_en(drive_en),
    .ser_a_out(ser_a_out), .ser_a_oe(ser_a_oe), .ser_b_out(ser_b_out),
    .ser_b_oe(ser_b_oe), .level(level)
  );

  // Behavioural reference model
  int m_bits[N];
  int m_code[N];
  int m_scl_prev;

  function automatic int ref_code(int d, int p, int en);
    if (en == 0) return 0;
    if (d != 0) return (p != 0) ? 0 : 3;
    return (p != 0) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bits[k]) begin m_bits[k] = 0; m_code[k] = 0; end
      m_scl_prev = 0;
    end else begin
      int nb[N];
      foreach (m_bits[k]) m_code[k] = ref_code(m_bits[k], polarity, drive_en);
      if (m_scl_prev == 1 && scl == 1'b0) begin
        nb = m_bits;
        if (!dir_rev) begin
          for (int k = N - 1; k > 0; k--) nb[k] = m_bits[k-1];
          nb[0] = ser_a_in;
          if (split_mode) nb[H] = ser_c_in;
        end else begin
          for (int k = 0; k < N - 1; k++) nb[k] = m_bits[k+1];
          nb[N-1] = split_mode ? ser_c_in : ser_b_in;
          if (split_mode) nb[H-1] = ser_b_in;
        end
        m_bits = nb;
      end
      m_scl_prev = scl;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < N; k++)
        check(level[2*k +: 2] == m_code[k][1:0], "R7 per-cycle level", level[2*k +: 2], m_code[k]);
      check(ser_b_out == m_bits[N-1][0], "R9 ser_b_out", ser_b_out, m_bits[N-1]);
      check(ser_a_out == m_bits[0][0], "R9 ser_a_out", ser_a_out, m_bits[0]);
      check(ser_a_oe == dir_rev && ser_b_oe == !dir_rev, "R9 oe", {ser_a_oe, ser_b_oe}, {dir_rev, !dir_rev});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic shift_one(input logic a, input logic b, input logic c);
    ser_a_in = a; ser_b_in = b; ser_c_in = c;
    scl = 1'b1; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic chk_out(input int idx, input int exp, input string req);
    check(level[2*idx +: 2] == exp[1:0], req, level[2*idx +: 2], exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    tick(4);
    rst_n = 1'b1; tick(1);
    // R1: reset state
    check(level == '0, "R1 level after reset", level, 0);
    check(ser_a_out == 0 && ser_b_out == 0, "R1 serial after reset", {ser_a_out, ser_b_out}, 0);
    drive_en = 1'b1; tick(2);
    chk_out(3, 1, "R7 zero bit polarity 0 gives 01");

    // R3: forward, single chain
    shift_one(1, 0, 0);
    for (int k = 0; k < N - 1; k++) shift_one(0, 0, 0);
    chk_out(N - 1, 3, "R3 first bit at top output");
    chk_out(0, 1, "R3 last bit at output 0");
    check(ser_b_out == 1, "R9 cascade out at high end", ser_b_out, 1);

    // R2: rising/steady shift clock does not move the chain
    ser_a_in = 1'b1; scl = 1'b1; tick(5);
    chk_out(N - 1, 3, "R2 no shift on rising edge");
    chk_out(0, 1, "R2 no shift while steady");
    scl = 1'b0; tick(2);
    chk_out(0, 3, "R2 falling edge shifts");

    // R4: reverse, single chain
    dir_rev = 1'b1;
    shift_one(0, 1, 0);
    for (int k = 0; k < N - 1; k++) shift_one(0, 0, 0);
    chk_out(0, 3, "R4 first bit at output 0");
    chk_out(N - 1, 1, "R4 last bit at top output");
    check(ser_a_out == 1 && ser_a_oe == 1, "R9 cascade out at output-0 end", {ser_a_out, ser_a_oe}, 3);

    // R7: polarity high
    polarity = 1'b1; tick(2);
    chk_out(0, 0, "R7 one bit polarity 1 gives 00");
    chk_out(5, 2, "R7 zero bit polarity 1 gives 10");

    // R5: split forward
    dir_rev = 1'b0; split_mode = 1'b1;
    shift_one(1, 0, 1);
    for (int k = 0; k < H - 1; k++) shift_one(0, 0, 0);
    chk_out(H - 1, 0, "R5 lower half end");
    chk_out(N - 1, 0, "R5 upper half end");
    chk_out(H, 2, "R5 no carry across middle");
    chk_out(0, 2, "R5 lower half start");

    // R6: split reverse
    dir_rev = 1'b1;
    shift_one(0, 1, 1);
    for (int k = 0; k < H - 1; k++) shift_one(0, 0, 0);
    chk_out(0, 0, "R6 lower half end");
    chk_out(H, 0, "R6 upper half end");
    chk_out(H - 1, 2, "R6 no carry across middle");
    chk_out(N - 1, 2, "R6 upper half start");

    // R8: blanking
    drive_en = 1'b0; tick(2);
    check(level == '0, "R8 blanking forces 00", level, 0);
    polarity = 1'b0; tick(2);
    check(level == '0, "R8 blanking ignores polarity", level, 0);

    // Mixed pseudo-random stretch
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      scl = lfsr[0]; ser_a_in = lfsr[3]; ser_b_in = lfsr[5]; ser_c_in = lfsr[7];
      if (lfsr[9:8] == 2'b00) dir_rev = ~dir_rev;
      if (lfsr[11:10] == 2'b00) split_mode = ~split_mode;
      polarity = lfsr[12];
      drive_en = (lfsr[15:13] != 3'b000);
      tick(1);
    end
    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule